// File: doc/BRIEF.md
# Mixed-Sign Single-Cycle Multiplier

This block multiplies two 16-bit operands for a 16-bit datapath. It covers unsigned, signed and the two mixed-sign combinations with one 17x17 signed multiply array. Each operand is widened to 17 bits. The added top bit is a copy of the operand's MSB when that operand is signed, and zero when it is unsigned. One signed product therefore gives the correct value for all four combinations.

A width select picks between a full 16x16 product and an 8x8 product. In 8x8 mode only the low byte of each operand is used. The caller pulses `start` with the operands, mode and width. On the next clock edge the 32-bit product is registered and `prod_vld` is high for that one cycle. Between strobes the product register keeps its value.

Top module: `mixmul`

## Requirements
- R1: While `rst_n` is low, `prod` is 0 and `prod_vld` is 0.
- R2: `prod_vld` is high in the cycle after a clock edge that sampled `start` high, and low after every edge that sampled `start` low.
- R3: An edge that samples `start` low leaves `prod` unchanged.
- R4: With `sgn` = 2'b00 and `half` = 0, `prod` is the unsigned 32-bit product of `a` and `b`.
- R5: With `sgn` = 2'b01 and `half` = 0, `prod` is the two's-complement product of `a` and `b`, both taken as signed.
- R6: With `sgn` = 2'b10 and `half` = 0, `a` is signed and `b` is unsigned, and `prod` is their two's-complement product.
- R7: With `sgn` = 2'b11 and `half` = 0, `a` is unsigned and `b` is signed, and `prod` is their two's-complement product.
- R8: With `half` = 1, only `a[7:0]` and `b[7:0]` affect `prod`, each taken as signed or unsigned according to `sgn` as in R4 to R7. The upper bytes of `a` and `b` are ignored.
- R9: With `half` = 1, `prod[31:16]` is zero when `sgn` = 2'b00. For any other `sgn`, it repeats `prod[15]`.
- R10: The most negative operands give exact results. With `sgn` = 2'b01, 0x8000 times 0x8000 gives 0x40000000. With `half` = 1 and `sgn` = 2'b01, 0x80 times 0x80 gives 0x00004000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Multiply strobe, samples the operands |
| a | input | 16 | First operand |
| b | input | 16 | Second operand |
| sgn | input | 2 | Signedness: 00 uu, 01 ss, 10 a signed/b unsigned, 11 a unsigned/b signed |
| half | input | 1 | 1 selects the 8x8 product |
| prod | output | 32 | Registered product |
| prod_vld | output | 1 | High for one cycle when a new product is in `prod` |

## Verification
The hardest case to reach is a set of extension bits that actually change the result. This needs a negative operand in a signed slot next to an operand with its MSB set in an unsigned slot. Most negative values such as 0x8000 and 0x80 push this to the edge of the result range. Random operands seldom reach these combinations, so the stimulus runs a directed corner set (0x0000, 0x0001, 0x7FFF, 0x8000, 0xFFFF and their byte counterparts) through every mode and width. In 8x8 mode the upper bytes carry random values to show they are ignored. Random strobes with idle gaps follow, to exercise the hold and valid timing.

// File: rtl/mixmul.sv
module mixmul #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic [1:0]     sgn,
  input  logic           half,
  output logic [2*W-1:0] prod,
  output logic           prod_vld
);
  localparam int H  = W / 2;
  localparam int XW = W + 1;
  localparam int PW = 2 * W;

  logic a_s, b_s;
  logic signed [XW-1:0] ax, bx;
  logic signed [PW-1:0] full;

  assign a_s = (sgn == 2'b01) || (sgn == 2'b10);
  assign b_s = (sgn == 2'b01) || (sgn == 2'b11);

  assign ax = half ? {{(XW-H){a_s & a[H-1]}}, a[H-1:0]} : {a_s & a[W-1], a};
  assign bx = half ? {{(XW-H){b_s & b[H-1]}}, b[H-1:0]} : {b_s & b[W-1], b};

  assign full = ax * bx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod     <= '0;
      prod_vld <= 1'b0;
    end else begin
      prod_vld <= start;
      if (start) prod <= full;
    end
  end

  p_vld_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> prod_vld);
  p_no_vld_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !prod_vld);
  p_hold_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(prod));
  p_zext_half_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && half && sgn == 2'b00) |=> (prod[PW-1:W] == '0));
  p_sext_half_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && half && sgn != 2'b00) |=> (prod[PW-1:W] == {W{prod[W-1]}}));
  p_uu_nonneg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !half && sgn == 2'b00 && a[W-1] == 1'b0 && b[W-1] == 1'b0) |=> !prod[PW-1]);
endmodule

// File: tb/sim_mixmul.sv
module sim_mixmul;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        start = 0;
  logic [15:0] a = 0, b = 0;
  logic [1:0]  sgn = 0;
  logic        half = 0;
  logic [31:0] prod;
  logic        prod_vld;

  int checks = 0, fails = 0;
  logic [31:0] exp_prod;
  logic        exp_vld;
  string       exp_tag;

  always #5 clk = ~clk;

  mixmul u0 (.clk(clk), .rst_n(rst_n), .start(start), .a(a), .b(b),
             .sgn(sgn), .half(half), .prod(prod), .prod_vld(prod_vld));

  function automatic logic [31:0] ref_mul(logic [15:0] x, logic [15:0] y,
                                          logic [1:0] m, logic h);
    longint xv, yv;
    bit xs, ys;
    xs = (m == 2'b01) || (m == 2'b10);
    ys = (m == 2'b01) || (m == 2'b11);
    if (h) begin
      xv = xs ? longint'($signed(x[7:0])) : longint'(x[7:0]);
      yv = ys ? longint'($signed(y[7:0])) : longint'(y[7:0]);
    end else begin
      xv = xs ? longint'($signed(x)) : longint'(x);
      yv = ys ? longint'($signed(y)) : longint'(y);
    end
    return 32'(xv * yv);
  endfunction

  function automatic string tag_of(logic [15:0] x, logic [15:0] y,
                                   logic [1:0] m, logic h);
    if (m == 2'b01 && ((!h && x == 16'h8000 && y == 16'h8000) ||
                       (h && x[7:0] == 8'h80 && y[7:0] == 8'h80))) return "R10";
    if (h) return "R8 R9";
    case (m)
      2'b00: return "R4";
      2'b01: return "R5";
      2'b10: return "R6";
      default: return "R7";
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_prod <= 0;
      exp_vld  <= 0;
      exp_tag  <= "R1";
    end else begin
      exp_vld <= start;
      if (start) begin
        exp_prod <= ref_mul(a, b, sgn, half);
        exp_tag  <= tag_of(a, b, sgn, half);
      end else begin
        exp_tag <= "R3";
      end
    end
  end

  task automatic check_now();
    checks++;
    if (prod_vld !== exp_vld) begin
      fails++;
      $display("FAIL R2: prod_vld=%0b expected %0b", prod_vld, exp_vld);
    end else if (prod !== exp_prod) begin
      fails++;
      $display("FAIL %s: prod=%h expected %h (a=%h b=%h)", exp_tag, prod, exp_prod, a, b);
    end
  endtask

  task automatic cyc(logic s, logic [15:0] x, logic [15:0] y, logic [1:0] m, logic h);
    @(negedge clk);
    check_now();
    start = s; a = x; b = y; sgn = m; half = h;
  endtask

  logic [15:0] corners [6] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234};

  initial begin
    fork
      begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    join_none
    repeat (3) @(negedge clk);
    checks++;
    if (prod !== 32'd0 || prod_vld !== 1'b0) begin
      fails++;
      $display("FAIL R1: prod=%h vld=%0b expected 0 0", prod, prod_vld);
    end
    rst_n = 1;
    for (int h = 0; h < 2; h++)
      for (int m = 0; m < 4; m++)
        for (int i = 0; i < 6; i++)
          for (int j = 0; j < 6; j++) begin
            logic [15:0] x, y;
            x = corners[i];
            y = corners[j];
            if (h == 1) begin
              x = {16'($urandom) >> 8, 8'(x[7:0] | (x[15] ? 8'h80 : 8'h00))};
              y = {16'($urandom) >> 8, 8'(y[7:0] | (y[15] ? 8'h80 : 8'h00))};
            end
            cyc(1, x, y, 2'(m), 1'(h));
          end
    cyc(1, 16'h8000, 16'h8000, 2'b01, 0);
    cyc(0, 16'hFFFF, 16'hFFFF, 2'b00, 0);
    cyc(0, 16'h0000, 16'h0000, 2'b00, 1);
    cyc(1, 16'hAB80, 16'h5580, 2'b01, 1);
    cyc(0, 16'h1111, 16'h2222, 2'b10, 0);
    for (int k = 0; k < 2000; k++)
      cyc(1'($urandom_range(0, 2) != 0), 16'($urandom), 16'($urandom),
          2'($urandom), 1'($urandom));
    cyc(0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);
    @(negedge clk);
    check_now();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule